// File: doc/BRIEF.md
# Four-Way Tag Array with Not-Most-Recently-Used Replacement

This block holds the tags, valid bits and replacement state for a 64 KB, four-way set-associative data cache with 128-byte lines. It is indexed virtually and tagged physically, so a lookup takes two steps. In the first cycle the set index is taken from the virtual address. In the next cycle the physical tag from address translation arrives and is compared against the four stored tags of that set. The result gives hit or miss and the way that hit. On a miss it also proposes a victim way for the refill.

Replacement keeps one small field per set: the number of the way touched most recently, by either a hit or a fill. A miss picks the lowest-numbered invalid way if one exists. If every way is valid, it picks the lowest-numbered way that is not the most recently used one. A refill controller writes the new tag back through the fill port. A flush command invalidates every line, for example on a process swap. It clears one set per clock and then pulses a done flag. Line data, the refill protocol and dirty writeback live elsewhere.

With the default parameters, addresses are 32 bits. Bits [6:0] are the line offset, bits [13:7] select one of 128 sets, and the stored tag is 18 bits wide.

Top module: `dcache_tag_nmru`

## Requirements
- R1: After reset no flush is in progress, `flush_done` and `res_valid` are low, and every line is invalid. A first lookup in any set therefore misses with victim way 0.
- R2: The set is selected only by `lk_vaddr[OFS_W+IDX_W-1:OFS_W]`. The line-offset bits and the bits above the index have no effect on the result.
- R3: A lookup accepted in cycle t gives `res_valid` high in cycle t+1 only. In that cycle `res_hit` is high exactly when a valid way of the set holds a tag equal to the `lk_ptag` presented in cycle t+1.
- R4: On a hit, `res_way` gives the binary number (0 to WAYS-1) of the matching way.
- R5: A fill writes `fill_tag` into way `fill_way` of set `fill_idx` and marks that way valid. A later lookup of that tag in that set hits that way.
- R6: A hit or an accepted fill makes the accessed way the most recently used way of its set.
- R7: On a miss in a set that has an invalid way, `res_victim` is the lowest-numbered invalid way.
- R8: On a miss in a set with all ways valid, `res_victim` is the lowest-numbered way other than the set's most recently used way. That is way 1 if way 0 is most recent, and way 0 otherwise.
- R9: A `flush_start` while idle raises `flush_busy` for exactly SETS cycles, clearing one set per cycle. It is followed by a one-cycle `flush_done` pulse. After that, every lookup misses with the lowest-numbered invalid way as victim.
- R10: While `flush_busy` is high, new lookups are not accepted (no `res_valid` in the following cycle) and fills are discarded. A tag offered by a discarded fill misses afterwards.
- R11: When a hit result and an accepted fill to the same set fall in the same cycle, the fill's way becomes the most recently used way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Start a lookup this cycle |
| lk_vaddr | input | ADDR_W | Virtual address of the lookup (index phase) |
| lk_ptag | input | TAG_W | Physical tag, presented the cycle after `lk_valid` |
| res_valid | output | 1 | Lookup result is present this cycle |
| res_hit | output | 1 | Lookup hit |
| res_way | output | WAY_W | Way that hit |
| res_victim | output | WAY_W | Way proposed for replacement on a miss |
| fill_en | input | 1 | Install a tag |
| fill_idx | input | IDX_W | Set of the fill |
| fill_way | input | WAY_W | Way of the fill |
| fill_tag | input | TAG_W | Tag to install |
| flush_start | input | 1 | Begin invalidating the whole array |
| flush_busy | output | 1 | Flush sweep in progress |
| flush_done | output | 1 | One-cycle pulse when the sweep ends |

## Verification
The bench builds the block with 16-bit addresses, a 512-byte capacity, four ways and 16-byte lines. This gives 8 sets, a 4-bit offset, a 3-bit index and a 9-bit tag. At that size, every set and way can be filled, hit and probed for its victim, and each most-recently-used state can be set up and checked against an arithmetic model. A whole flush sweep is short enough to count cycle by cycle. The bench also places lookups and fills inside a sweep to show they are ignored, and lines up a hit and a fill to the same set in one cycle.

// File: rtl/dcache_tag_nmru.sv
module dcache_tag_nmru #(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 65536,
  parameter int WAYS        = 4,
  parameter int LINE_BYTES  = 128,
  localparam int SETS  = CACHE_BYTES / (WAYS * LINE_BYTES),
  localparam int OFS_W = $clog2(LINE_BYTES),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [ADDR_W-1:0] lk_vaddr,
  input  logic [TAG_W-1:0] lk_ptag,
  output logic             res_valid,
  output logic             res_hit,
  output logic [WAY_W-1:0] res_way,
  output logic [WAY_W-1:0] res_victim,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             flush_start,
  output logic             flush_busy,
  output logic             flush_done
);
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAY_W-1:0] mru_q [SETS];

  logic             s2_v;
  logic [IDX_W-1:0] s2_idx;
  logic [IDX_W-1:0] fl_idx;
  logic [WAYS-1:0]  s2_vld, match;
  logic [WAY_W-1:0] s2_mru;

  wire [IDX_W-1:0] lk_idx = lk_vaddr[OFS_W +: IDX_W];
  wire unused_vaddr_bits = ^{lk_vaddr[ADDR_W-1:OFS_W+IDX_W], lk_vaddr[OFS_W-1:0]};

  assign s2_vld = vld_q[s2_idx];
  assign s2_mru = mru_q[s2_idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = s2_vld[w] && (tag_q[s2_idx][w] == lk_ptag);
  end

  always_comb begin
    res_way    = '0;
    res_victim = (s2_mru == '0) ? WAY_W'(1) : '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w])   res_way    = WAY_W'(w);
      if (!s2_vld[w]) res_victim = WAY_W'(w);
    end
  end

  assign res_valid = s2_v;
  assign res_hit   = |match;

  wire acc_fill = fill_en && !flush_busy;
  wire acc_hit  = s2_v && res_hit;

  always_ff @(posedge clk)
    if (acc_fill) tag_q[fill_idx][fill_way] <= fill_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        mru_q[s] <= '0;
      end
      s2_v       <= 1'b0;
      s2_idx     <= '0;
      fl_idx     <= '0;
      flush_busy <= 1'b0;
      flush_done <= 1'b0;
    end else begin
      s2_v       <= lk_valid && !flush_busy;
      s2_idx     <= lk_idx;
      flush_done <= 1'b0;
      if (flush_busy) begin
        vld_q[fl_idx] <= '0;
        fl_idx        <= fl_idx + 1'b1;
        if (fl_idx == IDX_W'(SETS - 1)) begin
          flush_busy <= 1'b0;
          flush_done <= 1'b1;
        end
      end else if (flush_start) begin
        flush_busy <= 1'b1;
        fl_idx     <= '0;
      end
      if (acc_fill) vld_q[fill_idx][fill_way] <= 1'b1;
      if (acc_hit)  mru_q[s2_idx] <= res_way;
      if (acc_fill) mru_q[fill_idx] <= fill_way;
    end
  end
endmodule

// File: rtl/dcache_tag_nmru_chk.sv
module dcache_tag_nmru_chk #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             res_valid,
  input logic             res_hit,
  input logic [WAY_W-1:0] res_way,
  input logic [WAY_W-1:0] res_victim,
  input logic             flush_busy,
  input logic             flush_done,
  input logic [WAYS-1:0]  set_vld,
  input logic [WAY_W-1:0] set_mru
);
  assert_result_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(lk_valid));

  assert_hit_way_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> set_vld[res_way]);

  assert_invalid_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit && !(&set_vld)) |-> !set_vld[res_victim]);

  assert_victim_not_mru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit && (&set_vld)) |-> (res_victim != set_mru));

  assert_done_after_sweep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> ($past(flush_busy) && !flush_busy));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);

  assert_no_result_in_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !$past(flush_busy));
endmodule

bind dcache_tag_nmru dcache_tag_nmru_chk #(.WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .res_valid(res_valid),
  .res_hit(res_hit), .res_way(res_way), .res_victim(res_victim),
  .flush_busy(flush_busy), .flush_done(flush_done),
  .set_vld(s2_vld), .set_mru(s2_mru)
);

// File: tb/sim_dcache_tag_nmru.sv
module sim_dcache_tag_nmru;
  localparam int AW = 16, NS = 8, NW = 4, OW = 4, IW = 3, TW = 9, WW = 2;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, fill_en = 0, flush_start = 0;
  logic [AW-1:0] lk_vaddr = '0;
  logic [TW-1:0] lk_ptag = '0, fill_tag = '0;
  logic [IW-1:0] fill_idx = '0;
  logic [WW-1:0] fill_way = '0;
  logic res_valid, res_hit, flush_busy, flush_done;
  logic [WW-1:0] res_way, res_victim;

  always #2.5 clk = ~clk;

  dcache_tag_nmru #(.ADDR_W(AW), .CACHE_BYTES(512), .WAYS(NW), .LINE_BYTES(16)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_ptag(lk_ptag),
    .res_valid(res_valid), .res_hit(res_hit), .res_way(res_way), .res_victim(res_victim),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_way(fill_way), .fill_tag(fill_tag),
    .flush_start(flush_start), .flush_busy(flush_busy), .flush_done(flush_done));

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [TW-1:0] mtag [NS][NW];
  bit mvld [NS][NW];
  int mmru [NS];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_victim(input int s);
    for (int w = 0; w < NW; w++) if (!mvld[s][w]) return w;
    return (mmru[s] == 0) ? 1 : 0;
  endfunction

  function automatic int model_hit(input int s, input logic [TW-1:0] t);
    for (int w = 0; w < NW; w++) if (mvld[s][w] && mtag[s][w] == t) return w;
    return -1;
  endfunction

  function automatic bit model_full(input int s);
    for (int w = 0; w < NW; w++) if (!mvld[s][w]) return 0;
    return 1;
  endfunction

  int salt = 0;
  task automatic lookup(input int s, input logic [TW-1:0] t);
    int hw;
    salt++;
    @(negedge clk);
    lk_valid = 1;
    lk_vaddr = {TW'(salt * 37 + 5), IW'(s), OW'(salt * 7)};
    @(negedge clk);
    lk_valid = 0;
    lk_ptag  = t;
    #1;
    hw = model_hit(s, t);
    chk(res_valid == 1, "R3 res_valid", int'(res_valid), 1);
    chk(res_hit == (hw >= 0), "R3/R2 hit", int'(res_hit), int'(hw >= 0));
    if (hw >= 0) begin
      chk(int'(res_way) == hw, "R4 way", int'(res_way), hw);
      mmru[s] = hw;
    end else if (model_full(s))
      chk(int'(res_victim) == model_victim(s), "R8 victim", int'(res_victim), model_victim(s));
    else
      chk(int'(res_victim) == model_victim(s), "R7 victim", int'(res_victim), model_victim(s));
  endtask

  task automatic fill(input int s, input int w, input logic [TW-1:0] t);
    @(negedge clk);
    if (!flush_busy) begin
      mtag[s][w] = t; mvld[s][w] = 1; mmru[s] = w;
    end
    fill_en = 1; fill_idx = IW'(s); fill_way = WW'(w); fill_tag = t;
    @(negedge clk);
    fill_en = 0;
  endtask

  function automatic logic [TW-1:0] tg(input int s, input int w);
    return TW'(s * 16 + w + 1);
  endfunction

  initial begin
    int n;
    for (int s = 0; s < NS; s++) begin
      mmru[s] = 0;
      for (int w = 0; w < NW; w++) begin mvld[s][w] = 0; mtag[s][w] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(flush_busy == 0, "R1 busy", int'(flush_busy), 0);
    chk(flush_done == 0, "R1 done", int'(flush_done), 0);
    chk(res_valid == 0, "R1 res_valid", int'(res_valid), 0);
    for (int s = 0; s < NS; s++) lookup(s, TW'(5));

    // R5/R7: fill every way, victim walks through invalid ways
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        lookup(s, tg(s, w));
        fill(s, w, tg(s, w));
      end

    // R4/R6/R8: hit each way, then probe victim
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        lookup(s, tg(s, w));
        lookup(s, TW'(9'h1FF));
      end

    // R11: hit on way 3 and fill way 0 of the same set in one cycle
    @(negedge clk);
    lk_valid = 1; lk_vaddr = {TW'(0), IW'(2), OW'(0)};
    @(negedge clk);
    lk_valid = 0; lk_ptag = tg(2, 3);
    fill_en = 1; fill_idx = IW'(2); fill_way = 2'd0; fill_tag = TW'(9'h0AA);
    #1;
    chk(res_hit == 1 && res_way == 2'd3, "R11 hit", int'(res_way), 3);
    mtag[2][0] = TW'(9'h0AA); mmru[2] = 0;
    @(negedge clk);
    fill_en = 0;
    lookup(2, TW'(9'h1FF));
    chk(mmru[2] == 0, "R11 mru", mmru[2], 0);
    lookup(2, TW'(9'h0AA));

    // R9: sweep length and done pulse
    @(negedge clk);
    flush_start = 1;
    @(negedge clk);
    flush_start = 0;
    n = 0;
    while (flush_busy && n < 1000) begin n++; @(negedge clk); end
    chk(n == NS, "R9 busy cycles", n, NS);
    chk(flush_done == 1, "R9 done", int'(flush_done), 1);
    @(negedge clk);
    chk(flush_done == 0, "R9 done pulse", int'(flush_done), 0);
    for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) mvld[s][w] = 0;
    for (int s = 0; s < NS; s++) lookup(s, tg(s, 1));

    // R10: lookup and fill during a sweep are ignored
    for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) fill(s, w, tg(s, w));
    @(negedge clk);
    flush_start = 1;
    @(negedge clk);
    flush_start = 0;
    lk_valid = 1; lk_vaddr = {TW'(0), IW'(1), OW'(0)};
    @(negedge clk);
    lk_valid = 0;
    @(negedge clk);
    chk(res_valid == 0, "R10 lookup ignored", int'(res_valid), 0);
    fill(1, 2, TW'(9'h055));
    n = 0;
    while (!flush_done && n < 1000) begin n++; @(negedge clk); end
    for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) mvld[s][w] = 0;
    lookup(1, TW'(9'h055));
    chk(mvld[1][2] == 0, "R10 fill ignored", int'(mvld[1][2]), 0);
    for (int s = 0; s < NS; s++) lookup(s, tg(s, 0));

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule